// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Channel

This block takes frames arriving as a byte stream, with a start marker on the first byte and an end marker on the last, and stores each of them in a memory buffer. Software describes the buffers through a ring of two-word descriptors. The first word carries the buffer size and a set of control bits. The second word carries the buffer address. When a frame starts, the channel reads the current descriptor. If software has handed that descriptor to the engine, the channel copies the frame bytes into the buffer one byte lane at a time. It then writes the first word back with the received length, the frame markers and the status bits, and hands the descriptor back to software. After that it moves on to the next descriptor, or returns to the ring start when the descriptor carries the wrap bit.

Software controls the channel through plain register inputs: the ring start address (loaded into the current pointer by a strobe), a channel enable, an interrupt mask and write-one-to-clear strobes for the interrupt status. The channel gives a level interrupt. It also gives a one-cycle pulse for each descriptor it returns, for use by an external buffer accountant. Each frame uses exactly one descriptor.

Top module: `rxd_chan`

## Requirements
- R1: Descriptor word 0 holds the buffer size in bits 27:16, the engine-owns flag in bit 15 and the wrap flag in bit 12. Word 1 holds the buffer address. The frame's n-th byte is written to buffer address + n, with only the byte enable of lane (address mod 4) set.
- R2: The write-back of word 0 sets the length field (bits 27:16), clears bit 15, sets both bit 14 (frame end) and bit 13 (frame start), and keeps bit 12 as it was fetched.
- R3: The ring pointer loads the ring start on the init strobe. It advances by 8 after each returned descriptor, and goes back to the ring start after a descriptor whose wrap bit is set.
- R4: A frame longer than the buffer size is truncated. No byte is written past the buffer, the length field equals the buffer size, and status bit 4 is set.
- R5: The stream error inputs at the end byte are written to status bits 0 (overflow), 1 (checksum error) and 2 (receive error). The length counts every byte received, including the 4 check bytes.
- R6: Interrupt status bit 0 (buffer done) and bit 1 (packet done) set when a descriptor is returned. Bit 2 (not owned) sets when a fetched descriptor belongs to software. Writing 1 clears a bit, but a set in the same cycle wins.
- R7: The interrupt output is high exactly when some status bit and the matching mask bit are both 1.
- R8: If the descriptor is not owned, the channel accepts and discards the whole frame, clears its enable and keeps the ring pointer on that descriptor.
- R9: Writing 0 to the enable lets the frame in progress finish. The enable reads 1 until the engine is idle. While it reads 0, the stream is not accepted and memory is not requested.
- R10: The accountant pulse lasts one cycle, once per returned descriptor, and does not fire for a dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W | Ring start address |
| ring_init | input | 1 | Strobe: load ring start into the current pointer |
| en_wr | input | 1 | Strobe: write the channel enable |
| en_wdata | input | 1 | Value written to the enable |
| en_rd | output | 1 | Enable readback, 1 until the engine is idle |
| irq_mask | input | 3 | Interrupt mask |
| irq_clr | input | 3 | Write-one-to-clear strobes for the status |
| irq_stat | output | 3 | Interrupt status |
| irq | output | 1 | Interrupt request |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_sop | input | 1 | First byte of a frame |
| s_eop | input | 1 | Last byte of a frame |
| s_err | input | 3 | Error flags, sampled with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| fc_pulse | output | 1 | One pulse per returned descriptor |

## Verification
The risky overlap is a software status clear that lands in the same cycle as a completed write-back setting the same status bits. To provoke it, the bench watches the memory port for the write-back of a known descriptor address and drives the clear strobes for exactly that edge. The bench then expects buffer-done and packet-done to read set, and expects a later, lone clear to empty them. A second overlap is a disable written while a frame is streaming. There the bench expects the enable to read 1 until that frame's descriptor is returned, and to read 0 afterwards.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 12;
  localparam int LEN_LSB    = 16;
  localparam int OWN_BIT    = 15;
  localparam int END_BIT    = 14;
  localparam int START_BIT  = 13;
  localparam int WRAP_BIT   = 12;
  localparam int OVSZ_BIT   = 4;
  localparam int ERR_W      = 3;
  localparam int IRQ_W      = 3;
  localparam int IRQ_BUF    = 0;
  localparam int IRQ_PKT    = 1;
  localparam int IRQ_NOWN   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_DATA, ST_DROP, ST_WB
  } rxd_st_e;

  function automatic logic [LEN_W-1:0] desc_len(input logic [WORD_W-1:0] w);
    return w[LEN_LSB +: LEN_W];
  endfunction

  function automatic logic desc_owned(input logic [WORD_W-1:0] w);
    return w[OWN_BIT];
  endfunction

  function automatic logic desc_wrap(input logic [WORD_W-1:0] w);
    return w[WRAP_BIT];
  endfunction

  function automatic logic [WORD_W-1:0] wb_word(input logic [LEN_W-1:0] len,
                                                input logic wrap,
                                                input logic [ERR_W-1:0] err,
                                                input logic ovsz);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[END_BIT]          = 1'b1;
    w[START_BIT]        = 1'b1;
    w[WRAP_BIT]         = wrap;
    w[OVSZ_BIT]         = ovsz;
    w[ERR_W-1:0]        = err;
    return w;
  endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              ring_init,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(rxd_pkg::DESC_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_addr <= '0;
    else if (ring_init) cur_addr <= ring_base;
    else if (advance)   cur_addr <= wrap ? ring_base : cur_addr + STEP;
  end
endmodule

// File: rtl/rxd_irq_ctl.sv
module rxd_irq_ctl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_vec) | set_vec;
  end

  assign irq = |(stat & mask);
endmodule

// File: rtl/rxd_frame_ctr.sv
module rxd_frame_ctr #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic [LEN_W-1:0] buf_len,
  output logic [LEN_W-1:0] cnt,
  output logic             room,
  output logic             trunc
);
  assign room = (cnt < buf_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      trunc <= 1'b0;
    end else if (start) begin
      cnt   <= '0;
      trunc <= 1'b0;
    end else if (beat) begin
      if (room) cnt   <= cnt + LEN_W'(1);
      else      trunc <= 1'b1;
    end
  end
endmodule

// File: rtl/rxd_chan.sv
module rxd_chan #(
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           ring_base,
  input  logic                        ring_init,
  input  logic                        en_wr,
  input  logic                        en_wdata,
  output logic                        en_rd,
  input  logic [rxd_pkg::IRQ_W-1:0]   irq_mask,
  input  logic [rxd_pkg::IRQ_W-1:0]   irq_clr,
  output logic [rxd_pkg::IRQ_W-1:0]   irq_stat,
  output logic                        irq,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic [rxd_pkg::BYTE_W-1:0]  s_data,
  input  logic                        s_sop,
  input  logic                        s_eop,
  input  logic [rxd_pkg::ERR_W-1:0]   s_err,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [rxd_pkg::WORD_W/8-1:0] mem_be,
  output logic [rxd_pkg::WORD_W-1:0]  mem_wdata,
  input  logic [rxd_pkg::WORD_W-1:0]  mem_rdata,
  output logic                        fc_pulse
);
  import rxd_pkg::*;

  localparam int BE_W   = WORD_W / 8;
  localparam int LANE_W = $clog2(BE_W);
  localparam logic [ADDR_W-1:0] W1_OFS = ADDR_W'(WORD_W / 8);

  rxd_st_e            st;
  logic               en_req;
  logic [LEN_W-1:0]   buf_len;
  logic               own_q;
  logic               wrap_q;
  logic [ADDR_W-1:0]  buf_base;
  logic [ERR_W-1:0]   err_q;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   frm_cnt;
  logic               room;
  logic               trunc;

  // named internal events, also used by the checker
  logic               beat;
  logic               data_wr;
  logic               desc_done;
  logic               notown_evt;
  logic               frm_start;
  logic               frm_end;

  assign beat       = s_valid && s_ready;
  assign data_wr    = (st == ST_DATA) && beat && room;
  assign desc_done  = (st == ST_WB);
  assign notown_evt = (st == ST_RD2) && !own_q;
  assign frm_start  = (st == ST_RD2) && own_q;
  assign frm_end    = beat && s_eop;

  assign s_ready  = (st == ST_DATA) || (st == ST_DROP);
  assign en_rd    = en_req || (st != ST_IDLE);
  assign fc_pulse = desc_done;

  // channel enable register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_req <= 1'b0;
    else if (notown_evt) en_req <= 1'b0;
    else if (en_wr)      en_req <= en_wdata;
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE: if (en_req && s_valid && s_sop) st <= ST_RD0;
        ST_RD0:  st <= ST_RD1;
        ST_RD1:  st <= ST_RD2;
        ST_RD2:  st <= own_q ? ST_DATA : ST_DROP;
        ST_DATA: if (frm_end) st <= ST_WB;
        ST_DROP: if (frm_end) st <= ST_IDLE;
        ST_WB:   st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // descriptor fields and end-of-frame status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_len  <= '0;
      own_q    <= 1'b0;
      wrap_q   <= 1'b0;
      buf_base <= '0;
      err_q    <= '0;
    end else begin
      if (st == ST_RD1) begin
        buf_len <= desc_len(mem_rdata);
        own_q   <= desc_owned(mem_rdata);
        wrap_q  <= desc_wrap(mem_rdata);
      end
      if (st == ST_RD2) buf_base <= mem_rdata[ADDR_W-1:0];
      if ((st == ST_DATA) && frm_end) err_q <= s_err;
    end
  end

  rxd_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .ring_init (ring_init),
    .advance   (desc_done),
    .wrap      (wrap_q),
    .cur_addr  (cur_addr)
  );

  rxd_frame_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (frm_start),
    .beat    ((st == ST_DATA) && beat),
    .buf_len (buf_len),
    .cnt     (frm_cnt),
    .room    (room),
    .trunc   (trunc)
  );

  logic [IRQ_W-1:0] irq_set;
  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_BUF]  = desc_done;
    irq_set[IRQ_PKT]  = desc_done;
    irq_set[IRQ_NOWN] = notown_evt;
  end

  rxd_irq_ctl #(.N(IRQ_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (irq_set),
    .clr_vec (irq_clr),
    .mask    (irq_mask),
    .stat    (irq_stat),
    .irq     (irq)
  );

  // memory master
  logic [ADDR_W-1:0] data_addr;
  assign data_addr = buf_base + ADDR_W'(frm_cnt);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_addr;
    mem_be    = '1;
    mem_wdata = '0;
    unique case (st)
      ST_RD0: mem_req = 1'b1;
      ST_RD1: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr + W1_OFS;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wb_word(frm_cnt, wrap_q, err_q, trunc);
      end
      ST_DATA: begin
        mem_addr  = data_addr;
        mem_be    = BE_W'(1) << data_addr[LANE_W-1:0];
        mem_wdata = {BE_W{s_data}};
        if (data_wr) begin
          mem_req = 1'b1;
          mem_we  = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxd_chan_chk.sv
module rxd_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_done,
  input logic              notown_evt,
  input logic              data_wr,
  input logic              en_req,
  input logic              en_rd,
  input logic              s_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [ADDR_W-1:0] buf_base,
  input logic [LEN_W-1:0]  buf_len,
  input logic [2:0]        irq_stat,
  input logic [2:0]        irq_mask,
  input logic              irq,
  input logic              fc_pulse
);
  AST_WB_HANDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> (mem_req && mem_we && !mem_wdata[15] && mem_wdata[14] && mem_wdata[13])); // R2
  AST_NO_WRITE_PAST_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> ((mem_addr - buf_base) < ADDR_W'(buf_len))); // R4
  AST_PKT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> (irq_stat[1] && irq_stat[0])); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_stat & irq_mask) == 3'b000) |-> !irq); // R7
  AST_NOTOWN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    notown_evt |=> (irq_stat[2] && !en_req)); // R8
  AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rd |-> (!s_ready && !mem_req)); // R9
  AST_FC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fc_pulse |=> !fc_pulse); // R10
endmodule

bind rxd_chan rxd_chan_chk #(.ADDR_W(ADDR_W), .LEN_W(rxd_pkg::LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_done  (desc_done),
  .notown_evt (notown_evt),
  .data_wr    (data_wr),
  .en_req     (en_req),
  .en_rd      (en_rd),
  .s_ready    (s_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .buf_base   (buf_base),
  .buf_len    (buf_len),
  .irq_stat   (irq_stat),
  .irq_mask   (irq_mask),
  .irq        (irq),
  .fc_pulse   (fc_pulse)
);

// File: tb/rxd_chan_test.sv
module rxd_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic        ring_init = 1'b0;
  logic        en_wr = 1'b0;
  logic        en_wdata = 1'b0;
  logic        en_rd;
  logic [2:0]  irq_mask = 3'b111;
  logic [2:0]  irq_clr = 3'b000;
  logic [2:0]  irq_stat;
  logic        irq;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = 8'h00;
  logic        s_sop = 1'b0;
  logic        s_eop = 1'b0;
  logic [2:0]  s_err = 3'b000;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic        fc_pulse;

  always #2.5 clk = ~clk;

  rxd_chan uut (.*);

  int n_vec = 0;
  int n_bad = 0;
  int fc_cnt = 0;
  bit done = 1'b0;

  logic [31:0] mem [0:255];

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (rst_n && fc_pulse) fc_cnt <= fc_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison against the interrupt and enable rules
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq === |(irq_stat & irq_mask), "R7 irq vs stat&mask", {31'b0, irq}, {31'b0, |(irq_stat & irq_mask)});
      chk(!(!en_rd && (s_ready || mem_req)), "R9 idle while disabled", {30'b0, s_ready, mem_req}, 32'h0);
    end
  end

  function automatic logic [31:0] mk_desc(input int len, input bit own, input bit wrap);
    return (32'(len) << 16) | (32'(own) << 15) | (32'(wrap) << 12);
  endfunction

  function automatic logic [31:0] exp_wb(input int len, input bit wrap, input logic [2:0] err, input bit ov);
    return (32'(len) << 16) | 32'h6000 | (32'(wrap) << 12) | (32'(ov) << 4) | 32'(err);
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic put_desc(input int idx, input int bufa, input int len, input bit own, input bit wrap);
    mem[(32'h100 + 8*idx) >> 2]     = mk_desc(len, own, wrap);
    mem[(32'h100 + 8*idx + 4) >> 2] = 32'(bufa);
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed, input logic [2:0] err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = seed + 8'(i);
      s_sop   = (i == 0);
      s_eop   = (i == n - 1);
      s_err   = (i == n - 1) ? err : 3'b000;
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_err = 3'b000;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_en(input bit v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic clear(input logic [2:0] c);
    @(negedge clk); irq_clr = c;
    @(negedge clk); irq_clr = 3'b000;
  endtask

  task automatic check_data(input int bufa, input int n, input logic [7:0] seed, input string req);
    bit ok = 1'b1;
    int bad_i = 0;
    for (int i = 0; i < n; i++)
      if (ok && rd_byte(bufa + i) !== seed + 8'(i)) begin ok = 1'b0; bad_i = i; end
    chk(ok, req, {24'b0, rd_byte(bufa + bad_i)}, {24'b0, seed + 8'(bad_i)});
  endtask

  task automatic report;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hEEEEEEEE;
    put_desc(0, 32'h200, 32, 1'b1, 1'b0);
    put_desc(1, 32'h240, 32, 1'b1, 1'b0);
    put_desc(2, 32'h280, 32, 1'b1, 1'b0);
    put_desc(3, 32'h2C0, 32, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_stat == 3'b000, "R6 reset status", {29'b0, irq_stat}, 32'h0);
    chk(!irq && !en_rd && !s_ready && !mem_req, "R9 reset outputs", {28'b0, irq, en_rd, s_ready, mem_req}, 32'h0);

    ring_init = 1'b1; @(negedge clk); ring_init = 1'b0;

    // frame offered while the channel is off is held
    s_valid = 1'b1; s_sop = 1'b1; s_data = 8'h99;
    repeat (5) @(negedge clk);
    chk(!s_ready && !mem_req, "R9 held while off", {30'b0, s_ready, mem_req}, 32'h0);
    s_valid = 1'b0; s_sop = 1'b0;

    write_en(1'b1);
    chk(en_rd, "R9 enable readback", {31'b0, en_rd}, 32'h1);

    // A: plain frame into descriptor 0
    send_frame(20, 8'h10, 3'b000);
    chk(mem[32'h100 >> 2] == exp_wb(20, 0, 3'b000, 0), "R2 writeback A", mem[32'h100 >> 2], exp_wb(20, 0, 3'b000, 0));
    check_data(32'h200, 20, 8'h10, "R1 data A");
    chk(irq_stat == 3'b011 && irq, "R6 done flags", {28'b0, irq, irq_stat}, 32'hB);
    chk(fc_cnt == 1, "R10 pulse count A", 32'(fc_cnt), 32'd1);

    clear(3'b001);
    chk(irq_stat == 3'b010, "R6 w1c bit0 only", {29'b0, irq_stat}, 32'h2);
    clear(3'b010);
    chk(irq_stat == 3'b000 && !irq, "R6 w1c bit1", {28'b0, irq, irq_stat}, 32'h0);

    // B: oversize frame into descriptor 1
    send_frame(40, 8'h40, 3'b000);
    chk(mem[32'h108 >> 2] == exp_wb(32, 0, 3'b000, 1), "R4 truncated writeback", mem[32'h108 >> 2], exp_wb(32, 0, 3'b000, 1));
    check_data(32'h240, 32, 8'h40, "R4 data kept in buffer");
    chk(rd_byte(32'h260) == 8'hEE, "R4 no byte past buffer", {24'b0, rd_byte(32'h260)}, 32'hEE);

    // C and D: error flags, wrap descriptor
    send_frame(10, 8'h80, 3'b010);
    chk(mem[32'h110 >> 2] == exp_wb(10, 0, 3'b010, 0), "R5 checksum flag", mem[32'h110 >> 2], exp_wb(10, 0, 3'b010, 0));
    send_frame(8, 8'hA0, 3'b101);
    chk(mem[32'h118 >> 2] == exp_wb(8, 1, 3'b101, 0), "R5 R2 flags and wrap kept", mem[32'h118 >> 2], exp_wb(8, 1, 3'b101, 0));
    check_data(32'h2C0, 8, 8'hA0, "R1 data D");
    chk(fc_cnt == 4, "R10 pulse count D", 32'(fc_cnt), 32'd4);
    clear(3'b111);

    // E: pointer wrapped to descriptor 0, which software still owns
    send_frame(6, 8'hC0, 3'b000);
    chk(irq_stat == 3'b100, "R8 not-owned flag", {29'b0, irq_stat}, 32'h4);
    chk(!en_rd, "R8 enable cleared", {31'b0, en_rd}, 32'h0);
    chk(mem[32'h100 >> 2] == exp_wb(20, 0, 3'b000, 0), "R8 descriptor untouched", mem[32'h100 >> 2], exp_wb(20, 0, 3'b000, 0));
    check_data(32'h200, 20, 8'h10, "R8 buffer untouched");
    chk(fc_cnt == 4, "R10 no pulse on drop", 32'(fc_cnt), 32'd4);

    // F: re-arm, pointer stayed on descriptor 0
    put_desc(0, 32'h200, 32, 1'b1, 1'b0);
    clear(3'b111);
    write_en(1'b1);
    send_frame(12, 8'h30, 3'b000);
    chk(mem[32'h100 >> 2] == exp_wb(12, 0, 3'b000, 0), "R3 R8 wrap and retry", mem[32'h100 >> 2], exp_wb(12, 0, 3'b000, 0));
    check_data(32'h200, 12, 8'h30, "R3 data F");

    // G: disable written mid-frame
    put_desc(1, 32'h240, 32, 1'b1, 1'b0);
    fork
      send_frame(16, 8'h50, 3'b000);
      begin
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        en_wr = 1'b1; en_wdata = 1'b0;
        @(negedge clk); en_wr = 1'b0;
        chk(en_rd, "R9 busy keeps enable", {31'b0, en_rd}, 32'h1);
      end
    join
    chk(!en_rd, "R9 enable drops after frame", {31'b0, en_rd}, 32'h0);
    chk(mem[32'h108 >> 2] == exp_wb(16, 0, 3'b000, 0), "R9 frame finished", mem[32'h108 >> 2], exp_wb(16, 0, 3'b000, 0));
    s_valid = 1'b1; s_sop = 1'b1;
    repeat (5) @(negedge clk);
    chk(!s_ready, "R9 stopped after disable", {31'b0, s_ready}, 32'h0);
    s_valid = 1'b0; s_sop = 1'b0;

    // H: clear in the write-back cycle
    put_desc(2, 32'h280, 32, 1'b1, 1'b0);
    clear(3'b111);
    write_en(1'b1);
    fork
      send_frame(5, 8'h70, 3'b000);
      begin
        @(negedge clk);
        while (!(mem_req && mem_we && mem_addr == 32'h110)) @(negedge clk);
        irq_clr = 3'b011;
        @(negedge clk); irq_clr = 3'b000;
      end
    join
    chk(irq_stat == 3'b011, "R6 set wins over clear", {29'b0, irq_stat}, 32'h3);
    irq_mask = 3'b100;
    @(negedge clk);
    chk(!irq, "R7 masked off", {31'b0, irq}, 32'h0);
    irq_mask = 3'b010;
    @(negedge clk);
    chk(irq, "R7 unmasked", {31'b0, irq}, 32'h1);
    clear(3'b011);
    chk(irq_stat == 3'b000 && !irq, "R6 clear after overlap", {28'b0, irq, irq_stat}, 32'h0);
    report();
  end
endmodule